// File: doc/BRIEF.md
# ATA Command and PIO Data Engine

This block sits behind the register decoder of a disk-controller channel. It takes the opcode that software writes into the command register, decides how the currently selected device should answer, and keeps the status and error bytes that software later reads. A command either opens a programmed-I/O transfer, completes at once, or aborts with a fixed code. An interrupt request is pulsed for every command that completes or aborts. Packet entry is the exception: it raises no interrupt.

Data moves through a 16-bit data port over a local word buffer. The buffer holds 512 bytes by default and can be made larger. An identify command streams 512 bytes out of the buffer, one word per read strobe. A packet command takes in a 12-byte command packet, one word per write strobe, and then pulses a hand-off strobe so that a packet interpreter outside this block can act on it. The identify contents and packet responses are loaded into the buffer through a separate preload port. Byte position in the current transfer is exported so that its progress can be seen.

Top module: `atae_engine`

## Requirements
- R1: After reset, status is 0x00, error is 0x01, irq and pkt_done are low, xfer_index is 0 and data_rd is 0.
- R2: Opcode 0xA0 with dev_kind 2 (packet device) clears busy (bit 7), write fault (bit 5) and error (bit 0), sets data request (bit 3), leaves the error register unchanged, sets xfer_index to 0 and raises no interrupt.
- R3: Opcode 0xA0 with any dev_kind other than 2 aborts: status 0x41, error 0x04, irq pulsed.
- R4: Opcode 0xEC with dev_kind 1 (disk), or opcode 0xA1 with any dev_kind, sets error to 0x00 and status to 0x58, sets xfer_index to 0, opens a 512-byte read transfer and pulses irq.
- R5: Opcode 0xEC with any dev_kind other than 1 aborts with status 0x41 and error 0x04, and pulses irq.
- R6: Opcode 0xEF clears busy, write fault and error, sets ready (bit 6) and seek complete (bit 4), keeps data request and the error register, and pulses irq.
- R7: Any opcode other than 0xA0, 0xA1, 0xEC and 0xEF aborts with status 0x41 and error 0x04, and pulses irq.
- R8: While a packet is being received, each data_we stores data_wr at byte index xfer_index (the low byte at the even address) and advances xfer_index by 2. On the write that reaches 12 bytes, data request clears and pkt_done is high for exactly one cycle.
- R9: A data_we when no packet is being received changes neither the buffer nor xfer_index.
- R10: During an identify transfer on a present device, data_rd shows the buffer word at xfer_index. Each data_re advances xfer_index by 2 and leaves busy, write fault and error at 0 and ready and seek complete at 1.
- R11: The read that brings xfer_index to 512 clears data request. After it, data_rd is 0 and further reads leave xfer_index at 512.
- R12: With dev_kind 0 or 3 (no device), data_rd is 0 and data_re leaves xfer_index unchanged.
- R13: irq is high only in the single cycle after a command write, and busy and data request are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_kind | input | 2 | Selected device: 0 none, 1 disk, 2 packet device, 3 none |
| cmd_we | input | 1 | Command register write strobe |
| cmd_op | input | 8 | Opcode written with cmd_we |
| data_we | input | 1 | Data port write strobe |
| data_wr | input | 16 | Data port write word |
| data_re | input | 1 | Data port read strobe |
| data_rd | output | 16 | Data port read word (combinational, word at current index) |
| pre_we | input | 1 | Buffer preload write strobe |
| pre_addr | input | 8 | Buffer preload word address |
| pre_data | input | 16 | Buffer preload word |
| status | output | 8 | Status byte |
| error | output | 8 | Error byte |
| irq | output | 1 | Interrupt request pulse |
| pkt_done | output | 1 | Received command packet is complete |
| xfer_index | output | 10 | Byte index of the current transfer |

## Verification
The bench goes after the last identify word and the read after it. A design that compares the index one step late would either drop word 255 or let a 257th read run past the buffer and never clear data request. It sends one data write after the sixth packet word and one during an identify. A design that does not gate writes on packet reception would overwrite buffer word 6, which shows up later when that word is read back. Absent-device reads are made in the middle of an identify, where a design that advances the index anyway returns the wrong word once the device is selected again. Set-features is issued after an abort and after packet entry, which catches designs that overwrite the status byte instead of editing only the named bits.

// File: rtl/atae_pkg.sv
package atae_pkg;

    // Status byte bit positions
    localparam int ST_BSY  = 7;
    localparam int ST_DRDY = 6;
    localparam int ST_DF   = 5;
    localparam int ST_DSC  = 4;
    localparam int ST_DRQ  = 3;
    localparam int ST_ERR  = 0;

    localparam logic [7:0] ST_ABORT   = 8'h41;
    localparam logic [7:0] ERR_ABORT  = 8'h04;
    localparam logic [7:0] ST_ID_OPEN = 8'h58;
    localparam logic [7:0] ERR_RESET  = 8'h01;

    // Opcodes
    localparam logic [7:0] OP_PACKET   = 8'hA0;
    localparam logic [7:0] OP_PKT_IDENT = 8'hA1;
    localparam logic [7:0] OP_IDENT    = 8'hEC;
    localparam logic [7:0] OP_FEATURES = 8'hEF;

    // Device kinds
    localparam logic [1:0] KIND_NONE = 2'd0;
    localparam logic [1:0] KIND_DISK = 2'd1;
    localparam logic [1:0] KIND_PKT  = 2'd2;

    typedef enum logic [1:0] {
        ACT_ABORT,
        ACT_PKT,
        ACT_IDENT,
        ACT_FEAT
    } act_e;

    typedef enum logic [1:0] {
        M_IDLE,
        M_PKT_IN,
        M_IDENT
    } mode_e;

    function automatic logic [7:0] st_clear_fault(input logic [7:0] st);
        logic [7:0] r;
        r = st;
        r[ST_BSY] = 1'b0;
        r[ST_DF]  = 1'b0;
        r[ST_ERR] = 1'b0;
        return r;
    endfunction

    function automatic logic kind_present(input logic [1:0] k);
        return (k == KIND_DISK) || (k == KIND_PKT);
    endfunction

endpackage

// File: rtl/atae_cmd_decode.sv
module atae_cmd_decode
    import atae_pkg::*;
(
    input  logic [7:0] op,
    input  logic [1:0] kind,
    output act_e       act
);

    always_comb begin
        case (op)
            OP_PACKET:    act = (kind == KIND_PKT)  ? ACT_PKT   : ACT_ABORT;  // R2 R3
            OP_PKT_IDENT: act = ACT_IDENT;                                    // R4
            OP_IDENT:     act = (kind == KIND_DISK) ? ACT_IDENT : ACT_ABORT;  // R4 R5
            OP_FEATURES:  act = ACT_FEAT;                                     // R6
            default:      act = ACT_ABORT;                                    // R7
        endcase
    end

endmodule

// File: rtl/atae_wordbuf.sv
module atae_wordbuf #(
    parameter int WORDS = 256,
    localparam int AW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          pre_we,
    input  logic [AW-1:0] pre_addr,
    input  logic [15:0]   pre_data,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_addr,
    input  logic [15:0]   eng_data,
    input  logic [AW-1:0] rd_addr,
    output logic [15:0]   rd_data
);

    logic [15:0] mem_q [WORDS];

    // Engine writes take priority over preload writes
    always_ff @(posedge clk) begin
        if (eng_we) begin
            mem_q[eng_addr] <= eng_data;
        end else if (pre_we) begin
            mem_q[pre_addr] <= pre_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/atae_engine.sv
module atae_engine
    import atae_pkg::*;
#(
    parameter int BUF_BYTES = 512,
    parameter int PKT_BYTES = 12,
    parameter int ID_BYTES  = 512,
    localparam int WORDS = BUF_BYTES / 2,
    localparam int AW    = $clog2(WORDS),
    localparam int IW    = $clog2(BUF_BYTES) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    dev_kind,
    input  logic          cmd_we,
    input  logic [7:0]    cmd_op,
    input  logic          data_we,
    input  logic [15:0]   data_wr,
    input  logic          data_re,
    output logic [15:0]   data_rd,
    input  logic          pre_we,
    input  logic [AW-1:0] pre_addr,
    input  logic [15:0]   pre_data,
    output logic [7:0]    status,
    output logic [7:0]    error,
    output logic          irq,
    output logic          pkt_done,
    output logic [IW-1:0] xfer_index
);

    localparam logic [IW-1:0] STEP    = IW'(2);
    localparam logic [IW-1:0] PKT_LEN = IW'(PKT_BYTES);
    localparam logic [IW-1:0] ID_LEN  = IW'(ID_BYTES);

    typedef struct packed {
        logic [7:0]    status;
        logic [7:0]    err;
        mode_e         mode;
        logic [IW-1:0] idx;
        logic [IW-1:0] len;
        logic          irq;
        logic          pkt_done;
    } eng_s;

    eng_s s_d, s_q;

    act_e          act;
    logic          buf_we;
    logic [AW-1:0] word_addr;
    logic [15:0]   rd_word;
    logic [IW-1:0] idx_next;
    logic          present;

    atae_cmd_decode u_dec (
        .op   (cmd_op),
        .kind (dev_kind),
        .act  (act)
    );

    assign word_addr = s_q.idx[AW:1];

    atae_wordbuf #(.WORDS(WORDS)) u_buf (
        .clk      (clk),
        .pre_we   (pre_we),
        .pre_addr (pre_addr),
        .pre_data (pre_data),
        .eng_we   (buf_we),
        .eng_addr (word_addr),
        .eng_data (data_wr),
        .rd_addr  (word_addr),
        .rd_data  (rd_word)
    );

    assign present  = kind_present(dev_kind);
    assign idx_next = s_q.idx + STEP;

    always_comb begin
        s_d          = s_q;
        s_d.irq      = 1'b0;
        s_d.pkt_done = 1'b0;
        buf_we       = 1'b0;

        if (cmd_we) begin
            unique case (act)
                ACT_PKT: begin
                    // R2: open packet reception, no interrupt
                    s_d.status           = st_clear_fault(s_q.status);
                    s_d.status[ST_DRQ]   = 1'b1;
                    s_d.idx              = '0;
                    s_d.len              = PKT_LEN;
                    s_d.mode             = M_PKT_IN;
                end
                ACT_IDENT: begin
                    // R4: open identify read transfer
                    s_d.status = ST_ID_OPEN;
                    s_d.err    = '0;
                    s_d.idx    = '0;
                    s_d.len    = ID_LEN;
                    s_d.mode   = M_IDENT;
                    s_d.irq    = 1'b1;
                end
                ACT_FEAT: begin
                    // R6: edit named bits only
                    s_d.status          = st_clear_fault(s_q.status);
                    s_d.status[ST_DRDY] = 1'b1;
                    s_d.status[ST_DSC]  = 1'b1;
                    s_d.irq             = 1'b1;
                end
                default: begin
                    // R3 R5 R7: abort
                    s_d.status = ST_ABORT;
                    s_d.err    = ERR_ABORT;
                    s_d.mode   = M_IDLE;
                    s_d.irq    = 1'b1;
                end
            endcase
        end else if (data_we && s_q.mode == M_PKT_IN) begin
            // R8: store word, advance, hand off at the end
            buf_we  = 1'b1;
            s_d.idx = idx_next;
            if (idx_next >= s_q.len) begin
                s_d.status[ST_DRQ] = 1'b0;
                s_d.mode           = M_IDLE;
                s_d.pkt_done       = 1'b1;
            end
        end else if (data_re && s_q.mode == M_IDENT && present) begin
            // R10: forced status bits while streaming
            s_d.status          = st_clear_fault(s_q.status);
            s_d.status[ST_DRDY] = 1'b1;
            s_d.status[ST_DSC]  = 1'b1;
            s_d.idx             = idx_next;
            if (idx_next >= s_q.len) begin
                // R11: transfer complete
                s_d.status[ST_DRQ] = 1'b0;
                s_d.mode           = M_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.status   <= 8'h00;
            s_q.err      <= ERR_RESET;
            s_q.mode     <= M_IDLE;
            s_q.idx      <= '0;
            s_q.len      <= '0;
            s_q.irq      <= 1'b0;
            s_q.pkt_done <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    // R12: zeros unless an identify stream is open on a present device
    assign data_rd    = (s_q.mode == M_IDENT && present) ? rd_word : 16'h0000;
    assign status     = s_q.status;
    assign error      = s_q.err;
    assign irq        = s_q.irq;
    assign pkt_done   = s_q.pkt_done;
    assign xfer_index = s_q.idx;

endmodule

// File: rtl/atae_chk.sv
module atae_chk
    import atae_pkg::*;
#(
    parameter int BUF_BYTES = 512,
    localparam int IW = $clog2(BUF_BYTES) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    dev_kind,
    input logic          cmd_we,
    input logic [7:0]    cmd_op,
    input logic          data_we,
    input logic          data_re,
    input logic [15:0]   data_rd,
    input logic [7:0]    status,
    input logic [7:0]    error,
    input logic          irq,
    input logic          pkt_done,
    input logic [IW-1:0] xfer_index
);

    logic known_op;
    assign known_op = (cmd_op == OP_PACKET) || (cmd_op == OP_PKT_IDENT) ||
                      (cmd_op == OP_IDENT)  || (cmd_op == OP_FEATURES);

    // R7
    unknown_op_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we && !known_op |=> status == 8'h41 && error == 8'h04 && irq);

    // R3
    pkt_nonpkt_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we && cmd_op == 8'hA0 && dev_kind != 2'd2 |=> status == 8'h41 && error == 8'h04 && irq);

    // R4
    ident_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we && ((cmd_op == 8'hEC && dev_kind == 2'd1) || cmd_op == 8'hA1)
        |=> status == 8'h58 && error == 8'h00 && irq && xfer_index == '0);

    // R6
    features_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we && cmd_op == 8'hEF
        |=> status[6] && status[4] && !status[7] && !status[5] && !status[0] && irq);

    // R12
    absent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_we && data_re && (dev_kind == 2'd0 || dev_kind == 2'd3) |-> data_rd == 16'h0000);

    // R12
    absent_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_we && !data_we && data_re && (dev_kind == 2'd0 || dev_kind == 2'd3) |=> $stable(xfer_index));

    // R13
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(cmd_we));

    // R13
    bsy_drq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[7] && status[3]));

    // R8
    pkt_done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> $past(data_we) && $past(status[3]) && !status[3]);

    // R8
    pkt_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done);

endmodule

bind atae_engine atae_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dev_kind   (dev_kind),
    .cmd_we     (cmd_we),
    .cmd_op     (cmd_op),
    .data_we    (data_we),
    .data_re    (data_re),
    .data_rd    (data_rd),
    .status     (status),
    .error      (error),
    .irq        (irq),
    .pkt_done   (pkt_done),
    .xfer_index (xfer_index)
);

// File: tb/sim_atae_engine.sv
`timescale 1ns/1ps
module sim_atae_engine;

    localparam int BUF_BYTES = 512;
    localparam int WORDS = BUF_BYTES / 2;
    localparam int AW = $clog2(WORDS);
    localparam int IW = $clog2(BUF_BYTES) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    dev_kind = 2'd0;
    logic          cmd_we = 1'b0;
    logic [7:0]    cmd_op = 8'h00;
    logic          data_we = 1'b0;
    logic [15:0]   data_wr = 16'h0;
    logic          data_re = 1'b0;
    logic [15:0]   data_rd;
    logic          pre_we = 1'b0;
    logic [AW-1:0] pre_addr = '0;
    logic [15:0]   pre_data = 16'h0;
    logic [7:0]    status, error;
    logic          irq, pkt_done;
    logic [IW-1:0] xfer_index;

    int errs = 0;
    int checks = 0;
    logic [15:0] bm [WORDS];

    always #2 clk = ~clk;

    atae_engine #(.BUF_BYTES(BUF_BYTES)) u0 (
        .clk(clk), .rst_n(rst_n), .dev_kind(dev_kind), .cmd_we(cmd_we), .cmd_op(cmd_op),
        .data_we(data_we), .data_wr(data_wr), .data_re(data_re), .data_rd(data_rd),
        .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
        .status(status), .error(error), .irq(irq), .pkt_done(pkt_done), .xfer_index(xfer_index)
    );

    // {kind, opcode, expected status, expected error, expected irq}
    localparam logic [39:0] VEC [12] = '{
        {8'd1, 8'hEC, 8'h58, 8'h00, 8'd1},   // R4
        {8'd1, 8'hA0, 8'h41, 8'h04, 8'd1},   // R3
        {8'd2, 8'hA0, 8'h48, 8'h04, 8'd0},   // R2
        {8'd2, 8'hEF, 8'h58, 8'h04, 8'd1},   // R6
        {8'd2, 8'hEC, 8'h41, 8'h04, 8'd1},   // R5
        {8'd0, 8'hEC, 8'h41, 8'h04, 8'd1},   // R5
        {8'd1, 8'h37, 8'h41, 8'h04, 8'd1},   // R7
        {8'd1, 8'hEF, 8'h50, 8'h04, 8'd1},   // R6
        {8'd0, 8'hA1, 8'h58, 8'h00, 8'd1},   // R4
        {8'd3, 8'hA0, 8'h41, 8'h04, 8'd1},   // R3
        {8'd1, 8'h00, 8'h41, 8'h04, 8'd1},   // R7
        {8'd2, 8'hA1, 8'h58, 8'h00, 8'd1}    // R4
    };

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [7:0] op);
        @(negedge clk);
        cmd_we = 1'b1;
        cmd_op = op;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic wr_word(input logic [15:0] d);
        data_we = 1'b1;
        data_wr = d;
        @(negedge clk);
        data_we = 1'b0;
    endtask

    task automatic rd_word(output logic [15:0] v);
        v = data_rd;
        data_re = 1'b1;
        @(negedge clk);
        data_re = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(status == 8'h00, "R1 status", status, 8'h00);
        chk(error == 8'h01, "R1 error", error, 8'h01);
        chk(!irq && !pkt_done, "R1 irq/pkt_done", {irq, pkt_done}, 0);
        chk(xfer_index == 0 && data_rd == 0, "R1 index/data", xfer_index, 0);

        // preload buffer (works regardless of reset)
        for (int i = 0; i < WORDS; i++) begin
            pre_we = 1'b1;
            pre_addr = AW'(i);
            pre_data = {8'(i) ^ 8'h5A, 8'(i)};
            bm[i] = {8'(i) ^ 8'h5A, 8'(i)};
            @(negedge clk);
        end
        pre_we = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // command vector table
        for (int i = 0; i < 12; i++) begin
            dev_kind = VEC[i][33:32];
            issue(VEC[i][31:24]);
            chk(status == VEC[i][23:16], $sformatf("R2-7 vec%0d status", i), status, VEC[i][23:16]);
            chk(error == VEC[i][15:8], $sformatf("R2-7 vec%0d error", i), error, VEC[i][15:8]);
            chk(irq == VEC[i][0], $sformatf("R13 vec%0d irq", i), irq, VEC[i][0]);
        end

        // identify stream on a disk
        dev_kind = 2'd1;
        issue(8'hEC);
        chk(xfer_index == 0, "R4 index", xfer_index, 0);
        @(negedge clk);
        chk(!irq, "R13 irq single cycle", irq, 0);
        for (int i = 0; i < WORDS; i++) begin
            rd_word(v);
            chk(v == bm[i], $sformatf("R10 word %0d", i), v, bm[i]);
            if (i == 100) begin
                chk(status == 8'h58, "R10 status mid", status, 8'h58);
                chk(xfer_index == 202, "R10 index mid", xfer_index, 202);
            end
        end
        chk(status == 8'h50, "R11 drq cleared", status, 8'h50);
        chk(xfer_index == 512, "R11 index end", xfer_index, 512);
        rd_word(v);
        chk(v == 0, "R11 data after end", v, 0);
        chk(xfer_index == 512, "R11 index held", xfer_index, 512);

        // packet reception
        dev_kind = 2'd2;
        issue(8'hA0);
        chk(status == 8'h58 && error == 8'h00, "R2 status", {status, error}, 16'h5800);
        chk(!irq && xfer_index == 0, "R2 no irq, index 0", {irq, xfer_index}, 0);
        for (int i = 0; i < 6; i++) begin
            bm[i] = 16'hC0D0 + 16'(i);
            wr_word(bm[i]);
            chk(pkt_done == (i == 5), $sformatf("R8 pkt_done %0d", i), pkt_done, (i == 5));
            chk(xfer_index == IW'(2 * i + 2), $sformatf("R8 index %0d", i), xfer_index, 2 * i + 2);
        end
        chk(status == 8'h50, "R8 drq cleared", status, 8'h50);
        @(negedge clk);
        chk(!pkt_done, "R8 pkt_done pulse", pkt_done, 0);
        wr_word(16'hDEAD);
        chk(xfer_index == 12, "R9 idle write index", xfer_index, 12);

        // read back packet through a packet identify
        issue(8'hA1);
        for (int i = 0; i < 7; i++) begin
            rd_word(v);
            chk(v == bm[i], $sformatf("R8 R9 readback %0d", i), v, bm[i]);
        end
        chk(xfer_index == 14, "R10 index", xfer_index, 14);
        wr_word(16'hBEEF);
        chk(xfer_index == 14, "R9 write during identify", xfer_index, 14);

        // absent device
        dev_kind = 2'd0;
        #1;
        chk(data_rd == 0, "R12 data zero", data_rd, 0);
        rd_word(v);
        chk(v == 0 && xfer_index == 14, "R12 read held", {v, 6'd0, xfer_index}, 14);
        dev_kind = 2'd3;
        rd_word(v);
        chk(v == 0 && xfer_index == 14, "R12 kind3 held", {v, 6'd0, xfer_index}, 14);
        dev_kind = 2'd2;
        #1;
        chk(data_rd == bm[7], "R12 R9 resume word", data_rd, bm[7]);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule